// File: doc/BRIEF.md
# Console Memory Decode and Wait-State Generator

This block sits between a 16-bit CPU and the console's memory map. On each accepted access it classifies the address into a region, asserts that region's chip select and holds the CPU's ready line low for as long as the region needs. The boot ROM area and the scratch-pad area are true 16-bit paths and finish in the normal two-clock cycle. Every other address goes through the 8-bit multiplexing path, which stretches the cycle. The sound, speech and video peripherals use a fixed stretch. The slow serial-ROM region holds the CPU for a long stretch that is set by a parameter.

Two software control bits are written through a small bit-write port. The first bit adds one wait clock to every read of the video data port, and has no effect on any other access. The second bit turns on a fast 16-bit RAM that answers the expansion ranges with no wait states. When the fast RAM is off, those ranges take the multiplexed path. While a video read is in progress, the multiplexer-drive output stays low, because the video chip answers directly on its own half of the bus.

An access is accepted at a rising edge where `mem_req` is high and the block is idle. The chip selects rise at that edge. Ready then stays low for W clocks, goes high for one final clock, and the selects drop at the edge that follows. The block then spends one idle clock with ready high before it accepts another access. A zero-wait access therefore lasts two clocks: the accept clock and the final clock.

Top module: `busdec_waitgen`

## Requirements
- R1: After reset, `cpu_ready` is 1, `mux_on` is 0, every chip select is 0, and both control bits are cleared. With the bits cleared, a video read takes 4 wait clocks and address 0xA000 takes the 4-clock multiplexed path.
- R2: Addresses 0x0000–0x1FFF (`cs_boot`) and 0x8000–0x83FF (`cs_pad`) complete with zero wait clocks, and `mux_on` stays 0 while they run.
- R3: Exactly one chip select is active per access, from the accept edge through the final clock. The selects are: sound 0x8400–0x87FF, video 0x8800–0x8FFF (`cs_video_rd` when `cpu_rd`=1 and `cs_video_wr` when `cpu_rd`=0), speech 0x9000–0x97FF, and serial ROM 0x9800–0x9FFF. Other multiplexed addresses assert no select.
- R4: Sound, speech, video writes and every unlisted address hold `cpu_ready` low for exactly MUX_WAIT clocks (default 4).
- R5: A serial-ROM access holds `cpu_ready` low for exactly SROM_WAIT clocks (default 26).
- R6: `mux_on` is 1 during every multiplexed access except video reads, where it is 0.
- R7: A write of `ctl_din`=1 to control address 0x0400 adds VID_EXTRA clocks (default 1) to every video read. It adds nothing to video writes or to any other region.
- R8: A write of `ctl_din`=1 to control address 0x0402 enables the fast RAM. Addresses 0x2000–0x3FFF and 0xA000–0xFFFF then take zero wait clocks and assert `cs_xram`. With the bit at 0, these addresses take MUX_WAIT clocks and `cs_xram` stays 0.
- R9: While `cpu_ready` is low, the chip selects and `mux_on` hold their values, and any changes on `mem_req`, `cpu_addr` and `cpu_rd` have no effect on the current access.
- R10: A new access is accepted only after `cpu_ready` has been high for a clock with no select active. If `mem_req` is held high on zero-wait addresses, the accesses repeat every two clocks.
- R11: Control writes to any address other than 0x0400 and 0x0402 change neither control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_req | input | 1 | CPU memory access request, sampled when idle |
| cpu_rd | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 16 | CPU byte address |
| ctl_we | input | 1 | Control bit write strobe |
| ctl_addr | input | 16 | Control bit address (bit k at 0x0400 + 2k) |
| ctl_din | input | 1 | Value written to the addressed control bit |
| cpu_ready | output | 1 | Low while the CPU must hold |
| mux_on | output | 1 | Enables the 8-to-16-bit multiplexer response |
| cs_boot | output | 1 | Boot ROM select |
| cs_pad | output | 1 | Scratch-pad select |
| cs_sound | output | 1 | Sound chip select |
| cs_video_rd | output | 1 | Video read-data select |
| cs_video_wr | output | 1 | Video write select |
| cs_speech | output | 1 | Speech chip select |
| cs_srom | output | 1 | Serial ROM select |
| cs_xram | output | 1 | Fast expansion RAM select |

## Verification
The bench builds the block with its default parameters: MUX_WAIT 4, SROM_WAIT 26 and VID_EXTRA 1. With these values, each access in a full sweep finishes in at most about 30 clocks. The sweep covers all 256 address pages in both directions and under all four control-bit settings. Odd pages are probed at their top byte and even pages at their bottom byte, so every region boundary is reached from both sides. During every stretched access the bench scrambles the request inputs to test that the hold is stable.

// File: rtl/busdec_pkg.sv
// Shared types for the console memory decoder and wait-state generator.
// Assumes a 16-bit CPU byte address space.
package busdec_pkg;

    typedef enum logic [2:0] {
        RG_BOOT,
        RG_PAD,
        RG_SOUND,
        RG_VIDEO,
        RG_SPEECH,
        RG_SROM,
        RG_XRAM,
        RG_EXT
    } region_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_HOLD,
        SQ_LAST
    } seq_e;

    localparam int CTL_VWAIT   = 0;
    localparam int CTL_FASTRAM = 1;
    localparam int CTL_NUM     = 2;

    // True when an access to region r answers through the 8-bit multiplexer.
    function automatic logic via_mux(region_e r, logic rd);
        case (r)
            RG_SOUND, RG_SPEECH, RG_SROM, RG_EXT: via_mux = 1'b1;
            RG_VIDEO:                             via_mux = !rd;
            default:                              via_mux = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/busdec_region.sv
// Address region decoder and wait-count selector.
// Purely combinational. Assumes the control bits are stable while an access is accepted.
module busdec_region
    import busdec_pkg::*;
#(
    parameter int MUX_WAIT  = 4,
    parameter int SROM_WAIT = 26,
    parameter int VID_EXTRA = 1,
    parameter int CNT_W     = 5
) (
    input  logic [15:0]      addr,
    input  logic             rd,
    input  logic             vwait_en,
    input  logic             fast_en,
    output region_e          region,
    output logic [CNT_W-1:0] wait_n
);

    logic in_xram_range;

    // Classify the address into one region.
    always_comb begin
        in_xram_range = (addr >= 16'h2000 && addr <= 16'h3FFF) || (addr >= 16'hA000);
        if (addr <= 16'h1FFF)
            region = RG_BOOT;
        else if (addr >= 16'h8000 && addr <= 16'h83FF)
            region = RG_PAD;
        else if (addr >= 16'h8400 && addr <= 16'h87FF)
            region = RG_SOUND;
        else if (addr >= 16'h8800 && addr <= 16'h8FFF)
            region = RG_VIDEO;
        else if (addr >= 16'h9000 && addr <= 16'h97FF)
            region = RG_SPEECH;
        else if (addr >= 16'h9800 && addr <= 16'h9FFF)
            region = RG_SROM;
        else if (in_xram_range && fast_en)
            region = RG_XRAM;
        else
            region = RG_EXT;
    end

    // Select the number of hold clocks for the decoded region.
    always_comb begin
        case (region)
            RG_BOOT, RG_PAD, RG_XRAM: wait_n = '0;
            RG_SROM:                  wait_n = CNT_W'(SROM_WAIT);
            RG_VIDEO:                 wait_n = (rd && vwait_en) ? CNT_W'(MUX_WAIT + VID_EXTRA)
                                                                : CNT_W'(MUX_WAIT);
            default:                  wait_n = CNT_W'(MUX_WAIT);
        endcase
    end

endmodule

// File: rtl/busdec_ctlreg.sv
// Software control bits written one at a time through an address/data strobe.
// Bit k sits at CTL_BASE + CTL_STRIDE*k. Writes to any other address are ignored.
module busdec_ctlreg #(
    parameter int          NUM_BITS   = 2,
    parameter logic [15:0] CTL_BASE   = 16'h0400,
    parameter int          CTL_STRIDE = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [15:0]         addr,
    input  logic                din,
    output logic [NUM_BITS-1:0] bits
);

    for (genvar k = 0; k < NUM_BITS; k++) begin : g_bit
        localparam logic [15:0] BIT_ADDR = 16'(CTL_BASE + CTL_STRIDE * k);
        // Update control bit k when its own address is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bits[k] <= 1'b0;
            else if (we && addr == BIT_ADDR)
                bits[k] <= din;
        end
    end

endmodule

// File: rtl/busdec_seq.sv
// Access sequencer: accepts a request when idle, holds ready low for the
// latched wait count, then gives one final clock with ready high.
// Assumes the wait count is already valid in the same clock as the request.
module busdec_seq
    import busdec_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  region_e          region_i,
    input  logic             rd_i,
    input  logic [CNT_W-1:0] wait_i,
    output logic             ready,
    output logic             active,
    output region_e          region_q,
    output logic             rd_q
);

    seq_e             state;
    logic [CNT_W-1:0] cnt;

    // Walk idle -> hold (optional) -> last -> idle, latching the access at accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            cnt      <= '0;
            region_q <= RG_BOOT;
            rd_q     <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (req) begin
                        region_q <= region_i;
                        rd_q     <= rd_i;
                        cnt      <= wait_i;
                        state    <= (wait_i == '0) ? SQ_LAST : SQ_HOLD;
                    end
                end
                SQ_HOLD: begin
                    cnt <= cnt - CNT_W'(1);
                    if (cnt == CNT_W'(1))
                        state <= SQ_LAST;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Ready is low only while holding; selects are live outside idle.
    always_comb begin
        ready  = (state != SQ_HOLD);
        active = (state != SQ_IDLE);
    end

endmodule

// File: rtl/busdec_waitgen.sv
// Top: console memory decode and wait-state generator.
// Decodes each accepted CPU access, drives one chip select and the multiplexer
// enable for the whole access, and stretches the cycle per region through the
// CPU ready line. Assumes that mem_req, cpu_addr and cpu_rd are valid at the accept edge.
module busdec_waitgen
    import busdec_pkg::*;
#(
    parameter int          MUX_WAIT  = 4,
    parameter int          SROM_WAIT = 26,
    parameter int          VID_EXTRA = 1,
    parameter logic [15:0] CTL_BASE  = 16'h0400
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mem_req,
    input  logic        cpu_rd,
    input  logic [15:0] cpu_addr,
    input  logic        ctl_we,
    input  logic [15:0] ctl_addr,
    input  logic        ctl_din,
    output logic        cpu_ready,
    output logic        mux_on,
    output logic        cs_boot,
    output logic        cs_pad,
    output logic        cs_sound,
    output logic        cs_video_rd,
    output logic        cs_video_wr,
    output logic        cs_speech,
    output logic        cs_srom,
    output logic        cs_xram
);

    localparam int VID_MAX = MUX_WAIT + VID_EXTRA;
    localparam int WMAX    = (SROM_WAIT > VID_MAX) ? SROM_WAIT : VID_MAX;
    localparam int CNT_W   = $clog2(WMAX + 1) + 1;

    logic [CTL_NUM-1:0] ctl_bits;
    region_e            dec_region;
    logic [CNT_W-1:0]   dec_wait;
    region_e            region_q;
    logic               rd_q;
    logic               active;

    busdec_ctlreg #(
        .NUM_BITS   (CTL_NUM),
        .CTL_BASE   (CTL_BASE),
        .CTL_STRIDE (2)
    ) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .addr  (ctl_addr),
        .din   (ctl_din),
        .bits  (ctl_bits)
    );

    busdec_region #(
        .MUX_WAIT  (MUX_WAIT),
        .SROM_WAIT (SROM_WAIT),
        .VID_EXTRA (VID_EXTRA),
        .CNT_W     (CNT_W)
    ) u_dec (
        .addr     (cpu_addr),
        .rd       (cpu_rd),
        .vwait_en (ctl_bits[CTL_VWAIT]),
        .fast_en  (ctl_bits[CTL_FASTRAM]),
        .region   (dec_region),
        .wait_n   (dec_wait)
    );

    busdec_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (mem_req),
        .region_i (dec_region),
        .rd_i     (cpu_rd),
        .wait_i   (dec_wait),
        .ready    (cpu_ready),
        .active   (active),
        .region_q (region_q),
        .rd_q     (rd_q)
    );

    // Drive the chip selects and multiplexer enable from the latched access.
    always_comb begin
        cs_boot     = active && (region_q == RG_BOOT);
        cs_pad      = active && (region_q == RG_PAD);
        cs_sound    = active && (region_q == RG_SOUND);
        cs_video_rd = active && (region_q == RG_VIDEO) && rd_q;
        cs_video_wr = active && (region_q == RG_VIDEO) && !rd_q;
        cs_speech   = active && (region_q == RG_SPEECH);
        cs_srom     = active && (region_q == RG_SROM);
        cs_xram     = active && (region_q == RG_XRAM);
        mux_on      = active && via_mux(region_q, rd_q);
    end

endmodule

// File: rtl/busdec_waitgen_chk.sv
// Checker for busdec_waitgen, bound to every instance. It observes the ports only
// and measures the low time of ready with its own counter.
module busdec_waitgen_chk #(
    parameter int MUX_WAIT  = 4,
    parameter int SROM_WAIT = 26
) (
    input logic clk,
    input logic rst_n,
    input logic cpu_ready,
    input logic mux_on,
    input logic cs_boot,
    input logic cs_pad,
    input logic cs_sound,
    input logic cs_video_rd,
    input logic cs_video_wr,
    input logic cs_speech,
    input logic cs_srom,
    input logic cs_xram
);

    localparam int RW = 16;

    logic [7:0]    cs_vec;
    logic          cs_any;
    logic [RW-1:0] low_run;
    logic          ready_rose;

    always_comb begin
        cs_vec = {cs_xram, cs_srom, cs_speech, cs_video_wr,
                  cs_video_rd, cs_sound, cs_pad, cs_boot};
        cs_any = |cs_vec;
    end

    // Count consecutive clocks with ready low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_run <= '0;
        else if (!cpu_ready)
            low_run <= low_run + RW'(1);
        else
            low_run <= '0;
    end

    // Flag the clock in which ready returns high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ready_rose <= 1'b0;
        else
            ready_rose <= !cpu_ready;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (cpu_ready && cs_vec == 8'h00 && !mux_on));

    p_fast_no_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_boot || cs_pad) |-> (cpu_ready && !mux_on));

    p_single_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_vec));

    p_mux_hold_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && ready_rose && (cs_sound || cs_speech)) |-> (low_run == RW'(MUX_WAIT)));

    p_srom_hold_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && ready_rose && cs_srom) |-> (low_run == RW'(SROM_WAIT)));

    p_video_read_no_mux_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_video_rd |-> !mux_on);

    p_video_write_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && ready_rose && cs_video_wr) |-> (low_run == RW'(MUX_WAIT)));

    p_xram_no_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_xram |-> (cpu_ready && !mux_on));

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |=> ($stable(cs_vec) && $stable(mux_on)));

    p_accept_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_any) |-> $past(cpu_ready));

endmodule

bind busdec_waitgen busdec_waitgen_chk #(
    .MUX_WAIT  (MUX_WAIT),
    .SROM_WAIT (SROM_WAIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_ready   (cpu_ready),
    .mux_on      (mux_on),
    .cs_boot     (cs_boot),
    .cs_pad      (cs_pad),
    .cs_sound    (cs_sound),
    .cs_video_rd (cs_video_rd),
    .cs_video_wr (cs_video_wr),
    .cs_speech   (cs_speech),
    .cs_srom     (cs_srom),
    .cs_xram     (cs_xram)
);

// File: tb/busdec_waitgen_test.sv
// Sweep bench for busdec_waitgen: every address page, both directions, all
// control settings, plus reset, ignored-write and back-to-back cases.
module busdec_waitgen_test;

    localparam int CLK_NS = 10;
    localparam int MUXW   = 4;
    localparam int SROMW  = 26;
    localparam int VEXTRA = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        ctl_we = 1'b0;
    logic [15:0] ctl_addr = 16'h0000;
    logic        ctl_din = 1'b0;
    logic        cpu_ready, mux_on;
    logic        cs_boot, cs_pad, cs_sound, cs_video_rd, cs_video_wr;
    logic        cs_speech, cs_srom, cs_xram;
    logic [7:0]  cs_now;

    int total = 0;
    int bad = 0;
    bit vwait_on = 1'b0;
    bit fast_on = 1'b0;
    bit done = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    assign cs_now = {cs_xram, cs_srom, cs_speech, cs_video_wr,
                     cs_video_rd, cs_sound, cs_pad, cs_boot};

    busdec_waitgen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_req     (mem_req),
        .cpu_rd      (cpu_rd),
        .cpu_addr    (cpu_addr),
        .ctl_we      (ctl_we),
        .ctl_addr    (ctl_addr),
        .ctl_din     (ctl_din),
        .cpu_ready   (cpu_ready),
        .mux_on      (mux_on),
        .cs_boot     (cs_boot),
        .cs_pad      (cs_pad),
        .cs_sound    (cs_sound),
        .cs_video_rd (cs_video_rd),
        .cs_video_wr (cs_video_wr),
        .cs_speech   (cs_speech),
        .cs_srom     (cs_srom),
        .cs_xram     (cs_xram)
    );

    // Region codes: 0 boot, 1 pad, 2 sound, 3 video, 4 speech, 5 srom, 6 xram, 7 other.
    function automatic int region_of(logic [15:0] a);
        if (a < 16'h2000) return 0;
        if (a >= 16'h8000 && a < 16'h8400) return 1;
        if (a >= 16'h8400 && a < 16'h8800) return 2;
        if (a >= 16'h8800 && a < 16'h9000) return 3;
        if (a >= 16'h9000 && a < 16'h9800) return 4;
        if (a >= 16'h9800 && a < 16'hA000) return 5;
        if ((a < 16'h4000 || a >= 16'hA000) && fast_on) return 6;
        return 7;
    endfunction

    function automatic int exp_wait(logic [15:0] a, logic rd);
        case (region_of(a))
            0, 1, 6: return 0;
            3:       return MUXW + ((rd && vwait_on) ? VEXTRA : 0);
            5:       return SROMW;
            default: return MUXW;
        endcase
    endfunction

    function automatic logic [7:0] exp_cs(logic [15:0] a, logic rd);
        case (region_of(a))
            0: return 8'h01;
            1: return 8'h02;
            2: return 8'h04;
            3: return rd ? 8'h08 : 8'h10;
            4: return 8'h20;
            5: return 8'h40;
            6: return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit exp_mux(logic [15:0] a, logic rd);
        case (region_of(a))
            2, 4, 5, 7: return 1'b1;
            3:          return !rd;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic string wait_tag(logic [15:0] a, logic rd);
        case (region_of(a))
            0, 1: return "R2";
            3:    return rd ? "R7" : "R4";
            5:    return "R5";
            6:    return "R8";
            7:    return (a < 16'h4000 || a >= 16'hA000) ? "R8" : "R4";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic ctl_write(input logic [15:0] a, input logic d);
        @(negedge clk);
        ctl_we = 1'b1; ctl_addr = a; ctl_din = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    // One access; the request inputs are scrambled while the CPU is held (R9).
    task automatic run_access(input logic [15:0] a, input logic rd, input string tag_over);
        int         w, n;
        logic [7:0] ecs, snap;
        bit         em, msnap, stable_ok;
        string      wt;
        w   = exp_wait(a, rd);
        ecs = exp_cs(a, rd);
        em  = exp_mux(a, rd);
        wt  = (tag_over.len() != 0) ? tag_over : wait_tag(a, rd);
        @(negedge clk);
        check(cpu_ready && cs_now == 8'h00, "R10", "idle before accept", int'(cs_now), 0);
        mem_req = 1'b1; cpu_addr = a; cpu_rd = rd;
        @(negedge clk);
        snap = cs_now; msnap = mux_on; stable_ok = 1'b1; n = 0;
        while (!cpu_ready && n < 200) begin
            cpu_addr = ~a; cpu_rd = ~rd;
            @(negedge clk);
            n++;
            if (cs_now != snap || mux_on != msnap) stable_ok = 1'b0;
        end
        mem_req = 1'b0;
        check(n == w, wt, $sformatf("hold clocks at %h rd=%0d", a, rd), n, w);
        check(cs_now == ecs, "R3", $sformatf("select at %h rd=%0d", a, rd), int'(cs_now), int'(ecs));
        check(mux_on == em, "R6", $sformatf("mux_on at %h rd=%0d", a, rd), int'(mux_on), int'(em));
        if (w > 0)
            check(stable_ok && snap == ecs, "R9", $sformatf("held outputs at %h", a),
                  int'(snap), int'(ecs));
        @(negedge clk);
        check(cpu_ready && cs_now == 8'h00, "R10", "idle after final clock", int'(cs_now), 0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and cleared control bits
        check(cpu_ready == 1'b1, "R1", "ready after reset", int'(cpu_ready), 1);
        check(cs_now == 8'h00 && !mux_on, "R1", "selects after reset", int'(cs_now), 0);
        run_access(16'h8800, 1'b1, "R1");
        run_access(16'hA000, 1'b0, "R1");

        // Full sweep over pages, directions and control settings
        for (int c = 0; c < 4; c++) begin
            ctl_write(16'h0400, c[0]);
            ctl_write(16'h0402, c[1]);
            vwait_on = c[0];
            fast_on  = c[1];
            for (int p = 0; p < 256; p++) begin
                for (int r = 0; r < 2; r++) begin
                    run_access({p[7:0], (p[0] ? 8'hFF : 8'h00)}, r[0], "");
                end
            end
        end

        // R11: writes to neighbouring control addresses are ignored
        ctl_write(16'h0400, 1'b0);
        ctl_write(16'h0402, 1'b0);
        vwait_on = 1'b0; fast_on = 1'b0;
        ctl_write(16'h0401, 1'b1);
        ctl_write(16'h0404, 1'b1);
        ctl_write(16'h0403, 1'b1);
        ctl_write(16'h8400, 1'b1);
        run_access(16'h8BFE, 1'b1, "R11");
        run_access(16'h2000, 1'b1, "R11");
        run_access(16'hFFFF, 1'b0, "R11");

        // R7: extra wait on video reads only, with the bit set
        ctl_write(16'h0400, 1'b1);
        vwait_on = 1'b1;
        run_access(16'h8800, 1'b1, "R7");
        run_access(16'h8800, 1'b1, "R7");
        run_access(16'h8C00, 1'b0, "R7");
        run_access(16'h8400, 1'b1, "R7");

        // R10: request held high on a zero-wait address repeats every two clocks
        @(negedge clk);
        mem_req = 1'b1; cpu_addr = 16'h0010; cpu_rd = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(cs_boot == ((k % 2) == 0), "R10", $sformatf("back-to-back slot %0d", k),
                  int'(cs_boot), int'((k % 2) == 0));
        end
        mem_req = 1'b0;
        @(negedge clk);
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule